// File: doc/BRIEF.md
# Open-LED and Overtemperature Fault Monitor

This block watches the sixteen per-channel "output voltage below threshold" comparators of an LED sink driver and a single overtemperature comparator. It turns them into qualified fault flags and an active-low, open-drain style error request. A channel can only report an open LED once it has been switched on without a break for a qualification window. The window of each channel is longer than its lower neighbour's by a fixed stagger. This follows the staggered turn-on of the channel drivers.

The error request is a drive-low enable. The pad is pulled low while it is high and left floating otherwise. Blank hides open-LED faults from the error request, so a low pad with blank asserted points at a thermal fault alone. The qualified flags and the thermal flag are copied into a status snapshot when the latch input falls. The serial shift-out logic then reads that snapshot as the status word. All inputs are assumed to be synchronous to `clk`.

Top module: `led_fault_monitor`

## Requirements
- R1: `open_flag[n]` is high only when `chan_on[n]` and `volt_low[n]` are both high and `chan_on[n]` was sampled high on at least `QUAL_CYCLES + n*STAGGER_CYCLES` consecutive rising clock edges; once that run is reached it follows `chan_on[n] & volt_low[n]`.
- R2: A single clock edge with `chan_on[n]` low restarts the run of channel n, so the full window is needed again.
- R3: `therm_flag` equals `over_temp` in the same cycle, whatever `blank` is.
- R4: `err_drive_low` is high whenever `therm_flag` is high, or any `open_flag` bit is high while `blank` is low.
- R5: While `blank` is high, `err_drive_low` equals `therm_flag`; `open_flag` itself is not masked by blank.
- R6: On a rising edge where `latch` was high at the previous edge and is low now, `status_word` takes bits [NCH-1:0] = `open_flag` and bit [NCH] = `therm_flag`, using the values just before that edge.
- R7: On every other edge, including a rising `latch` or a steady `latch`, `status_word` keeps its value.
- R8: With `rst_n` low, all runs are cleared and `status_word` is zero; `open_flag` is zero after reset until a window completes.
- R9: With all channels switched on together, channel n+1 qualifies exactly `STAGGER_CYCLES` edges after channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_on | input | NCH | Per-channel sink enabled |
| volt_low | input | NCH | Per-channel output below open-LED threshold |
| over_temp | input | 1 | Overtemperature comparator |
| blank | input | 1 | Blank; masks open faults from the error request |
| latch | input | 1 | Latch strobe; its falling edge captures status |
| open_flag | output | NCH | Qualified open-LED flags |
| therm_flag | output | 1 | Thermal error flag |
| err_drive_low | output | 1 | Enable for pulling the error pad low |
| status_word | output | NCH+1 | Captured snapshot: thermal bit on top, open flags below |

## Verification
The bench switches all channels on together and measures each qualification edge. A design that ignored the stagger, or was off by one cycle in the window, would raise a flag an edge early or late. A one-cycle dropout of a channel is applied to show that its run restarts; a counter that only paused would re-qualify at once. Blank is applied together with open faults and with a thermal fault, which catches masking on the wrong flag. Latch pulses test that capture happens on the falling edge and not on the rising one or on a high level. Random traffic then checks all outputs against a bench model every cycle.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;
  function automatic int unsigned qual_limit(int unsigned base, int unsigned stagger,
                                             int unsigned idx);
    return base + idx * stagger;
  endfunction
endpackage

// File: rtl/lf_qual_timer.sv
module lf_qual_timer #(
  parameter int unsigned CW  = 8,
  parameter int unsigned LIM = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic vlow,
  output logic open_q
);
  localparam logic [CW-1:0] LIMV = CW'(LIM);
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= '0;
    else if (!on)        run <= '0;
    else if (run != LIMV) run <= run + 1'b1;
  end

  assign open_q = on && vlow && (run == LIMV);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (run == '0));
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run <= LIMV);
  assert_flag_after_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> $past(on));
endmodule

// File: rtl/lf_status_capture.sv
module lf_status_capture #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch,
  input  logic [W-1:0] snap_in,
  output logic [W-1:0] status
);
  logic latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      status  <= '0;
    end else begin
      latch_q <= latch;
      if (latch_q && !latch) status <= snap_in;
    end
  end

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !latch) |=> (status == $past(snap_in)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_q && !latch) |=> $stable(status));
endmodule

// File: rtl/led_fault_monitor.sv
module led_fault_monitor #(
  parameter int unsigned NCH            = 16,
  parameter int unsigned QUAL_CYCLES    = 40,
  parameter int unsigned STAGGER_CYCLES = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_on,
  input  logic [NCH-1:0] volt_low,
  input  logic           over_temp,
  input  logic           blank,
  input  logic           latch,
  output logic [NCH-1:0] open_flag,
  output logic           therm_flag,
  output logic           err_drive_low,
  output logic [NCH:0]   status_word
);
  import led_fault_pkg::*;
  localparam int unsigned MAXLIM = QUAL_CYCLES + (NCH - 1) * STAGGER_CYCLES;
  localparam int unsigned CW     = $clog2(MAXLIM + 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    lf_qual_timer #(
      .CW (CW),
      .LIM(qual_limit(QUAL_CYCLES, STAGGER_CYCLES, g))
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .on    (chan_on[g]),
      .vlow  (volt_low[g]),
      .open_q(open_flag[g])
    );
  end

  assign therm_flag    = over_temp;
  assign err_drive_low = therm_flag | ((|open_flag) & ~blank);

  lf_status_capture #(.W(NCH + 1)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch  (latch),
    .snap_in({therm_flag, open_flag}),
    .status (status_word)
  );

  assert_therm_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> err_drive_low);
  assert_blank_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !over_temp) |-> !err_drive_low);
  assert_open_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && (open_flag != '0)) |-> err_drive_low);
endmodule

// File: tb/led_fault_monitor_tb.sv
module led_fault_monitor_tb;
  localparam int NCH = 16;
  localparam int QUAL = 40;
  localparam int STG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] chan_on = '0, volt_low = '0;
  logic over_temp = 1'b0, blank = 1'b0, latch = 1'b0;
  logic [NCH-1:0] open_flag;
  logic therm_flag, err_drive_low;
  logic [NCH:0] status_word;

  int checks = 0, fails = 0;
  int run [NCH];
  logic prev_latch = 1'b0;
  logic [NCH:0] exp_status = '0;

  always #2 clk = ~clk;

  led_fault_monitor #(.NCH(NCH), .QUAL_CYCLES(QUAL), .STAGGER_CYCLES(STG)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .volt_low(volt_low),
    .over_temp(over_temp), .blank(blank), .latch(latch), .open_flag(open_flag),
    .therm_flag(therm_flag), .err_drive_low(err_drive_low), .status_word(status_word));

  function automatic int lim_of(int n);
    return QUAL + n * STG;
  endfunction

  function automatic logic [NCH-1:0] exp_flags();
    logic [NCH-1:0] f;
    for (int n = 0; n < NCH; n++) f[n] = chan_on[n] && volt_low[n] && (run[n] >= lim_of(n));
    return f;
  endfunction

  function automatic logic exp_err();
    return over_temp || ((exp_flags() != '0) && !blank);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model update on each rising edge (inputs stable since the previous falling edge)
  task automatic step();
    @(posedge clk);
    if (prev_latch && !latch) exp_status = {over_temp, exp_flags()};
    for (int n = 0; n < NCH; n++) run[n] = chan_on[n] ? (run[n] + 1) : 0;
    prev_latch = latch;
    @(negedge clk);
  endtask

  task automatic check_all();
    #1;
    chk("R1 open_flag", 64'(open_flag), 64'(exp_flags()));
    chk("R3 therm_flag", 64'(therm_flag), 64'(over_temp));
    chk(blank ? "R5 err_drive_low" : "R4 err_drive_low", 64'(err_drive_low), 64'(exp_err()));
    chk("R6/R7 status_word", 64'(status_word), 64'(exp_status));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int first_q [NCH];
    void'($urandom(1234));
    for (int n = 0; n < NCH; n++) run[n] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset status", 64'(status_word), 64'd0);
    chk("R8 reset flags", 64'(open_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 stagger and R1 window: all channels on, all low
    chan_on = '1; volt_low = '1;
    for (int n = 0; n < NCH; n++) first_q[n] = -1;
    for (int c = 1; c <= lim_of(NCH - 1) + 2; c++) begin
      step();
      #1;
      for (int n = 0; n < NCH; n++)
        if (open_flag[n] && first_q[n] < 0) first_q[n] = c;
    end
    chk("R1 ch0 window", 64'(first_q[0]), 64'(QUAL));
    for (int n = 1; n < NCH; n++)
      chk("R9 stagger", 64'(first_q[n] - first_q[n-1]), 64'(STG));

    // R5: blank masks open faults but open_flag stays
    blank = 1'b1; #1;
    chk("R5 blank masks open", 64'(err_drive_low), 64'd0);
    chk("R5 flag unmasked", 64'(open_flag), 64'hFFFF);
    over_temp = 1'b1; #1;
    chk("R3 therm under blank", 64'(therm_flag), 64'd1);
    chk("R4 therm drives err", 64'(err_drive_low), 64'd1);
    over_temp = 1'b0; blank = 1'b0; #1;
    chk("R4 open drives err", 64'(err_drive_low), 64'd1);

    // R7: rising latch and high latch do not capture; R6 falling does
    latch = 1'b1; step(); step();
    #1 chk("R7 no capture on rise", 64'(status_word), 64'd0);
    over_temp = 1'b1;
    latch = 1'b0; step();
    #1 chk("R6 capture on fall", 64'(status_word), {47'd0, 1'b1, 16'hFFFF});
    over_temp = 1'b0; step();
    #1 chk("R7 hold after capture", 64'(status_word), {47'd0, 1'b1, 16'hFFFF});
    exp_status = status_word;

    // R2: one-cycle dropout of channel 0 restarts its window
    chan_on[0] = 1'b0; step();
    chan_on[0] = 1'b1;
    for (int c = 1; c < QUAL; c++) step();
    #1 chk("R2 restart not yet", 64'(open_flag[0]), 64'd0);
    step();
    #1 chk("R2 restart requalified", 64'(open_flag[0]), 64'd1);

    // Constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int n = 0; n < NCH; n++) begin
        if ($urandom_range(0, 59) == 0) chan_on[n] = ~chan_on[n];
        volt_low[n] = ($urandom_range(0, 3) != 0);
      end
      if ($urandom_range(0, 29) == 0) over_temp = ~over_temp;
      blank = ($urandom_range(0, 3) == 0);
      latch = ($urandom_range(0, 7) == 0);
      check_all();
      step();
    end
    check_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule